// File: doc/BRIEF.md
# Byte-Lane Pipelined Synchronous Memory

This block is a single-port, 32-bit-wide synchronous memory with four independently writable byte lanes and a registered read path. Address, control and write data are sampled on the rising clock edge into an input stage. The memory is updated, or read into an output register, on the edge that follows. A read therefore presents its data one clock after its address was captured, and back-to-back accesses are accepted every cycle.

Two write controls coexist. An active-low global write stores the whole word. An active-low byte-write enable, qualified by four active-low lane selects, stores only the chosen bytes. Any cycle that is selected and writes no lane is a read. The output is split into a data bus and a valid flag. The valid flag is the registered read-valid masked by an active-low output enable that acts without waiting for a clock. The data bus is forced to zero whenever the flag is low. The access address is supplied by an external address/burst unit. The word depth is set by a parameter, with a small default.

Top module: `sram_bw_top`

## Requirements
- R1: While reset is low, and after it is released before any read has been issued, `rdValid` is 0 and `rdData` is 0.
- R2: With `selN`=0, `gwN`=1 and `bweN`=0, each lane `i` whose `bselN[i]` is 0 stores `wrData[8*i+7:8*i]` (lane 0 = bits 7:0 up to lane 3 = bits 31:24). Every lane whose select is 1 keeps its previous contents.
- R3: With `selN`=0 and `gwN`=0, all four lanes are written, whatever the values of `bweN` and `bselN`.
- R4: With `gwN`=1 and `bweN`=1, the lane selects are ignored. The cycle is a read and the stored word is unchanged.
- R5: With `gwN`=1, `bweN`=0 and `bselN`=4'b1111, the cycle is a read.
- R6: For a selected read captured at rising edge k, `rdData` holds the stored word and `rdValid` is 1 after edge k+1, provided `oeN` is 0.
- R7: A cycle captured with `selN`=1 writes nothing. After the next edge, `rdValid` is 0.
- R8: `oeN`=1 forces `rdValid` to 0 at once, without a clock edge. Returning it to 0 restores the pending read data in the same cycle.
- R9: A read of an address returns the merge of all earlier writes to it, including a write in the immediately preceding cycle.
- R10: A cycle captured as a write yields `rdValid`=0 after the following edge.
- R11: `rdData` is all zeros whenever `rdValid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of the control and output registers |
| selN | input | 1 | Active-low device select, sampled each edge |
| addr | input | ADDR_W | Word address from the address/burst unit |
| gwN | input | 1 | Active-low global write, all lanes |
| bweN | input | 1 | Active-low byte-write enable qualifying `bselN` |
| bselN | input | 4 | Active-low lane selects, bit i covers data bits 8i+7:8i |
| wrData | input | 32 | Write data |
| oeN | input | 1 | Active-low output enable, asynchronous |
| rdData | output | 32 | Read data, zero when not valid |
| rdValid | output | 1 | Read data valid (stands in for a driven bus) |

## Verification
The assertions assume that the select and write controls are stable around each rising edge. They also assume that `oeN` is the only input expected to change the outputs between edges. The bench keeps to this by changing the synchronous inputs only on the falling edge. It moves `oeN` mid-cycle only in the dedicated output-enable test, and there it restores `oeN` before the next edge. Reads are issued only to addresses that were first written in full, so every expected word in the reference array is fully defined.

// File: rtl/sram_bw_pkg.sv
`timescale 1ns/1ps
package sram_bw_pkg;
  parameter int LANES  = 4;
  parameter int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // Strobes handed from the control stage to the datapath for one access.
  typedef struct packed {
    logic             rdEn;
    logic [LANES-1:0] laneWr;
  } strobe_t;
endpackage

// File: rtl/sram_bw_ctrl.sv
`timescale 1ns/1ps
module sram_bw_ctrl
  import sram_bw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             selN,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bselN,
  output strobe_t          strb
);
  logic [LANES-1:0] laneHit;
  logic             anyLane;
  strobe_t          strbNxt;

  // Per-lane qualification: a lane select counts only under byte-write enable.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneHit[i] = ~bweN & ~bselN[i];
  end

  assign anyLane = |laneHit;

  always_comb begin
    strbNxt.rdEn = ~selN & gwN & ~anyLane;
    for (int i = 0; i < LANES; i++) begin
      strbNxt.laneWr[i] = ~selN & (~gwN | laneHit[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) strb <= '0;
    else       strb <= strbNxt;
  end
endmodule

// File: rtl/sram_bw_datapath.sv
`timescale 1ns/1ps
module sram_bw_datapath
  import sram_bw_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           strb,
  input  logic              oeN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] rdQ;
  logic              rdValidQ;

  // Input capture, aligned with the strobe register in the control stage.
  always_ff @(posedge clk) begin
    addrQ   <= addr;
    wrDataQ <= wrData;
  end

  // One storage array per byte lane; each has its own write strobe.
  for (genvar g = 0; g < LANES; g++) begin : g_mem
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strb.laneWr[g]) laneMem[addrQ] <= wrDataQ[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (!rstN)          rdQ[g*LANE_W +: LANE_W] <= '0;
      else if (strb.rdEn) rdQ[g*LANE_W +: LANE_W] <= laneMem[addrQ];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValidQ <= 1'b0;
    else       rdValidQ <= strb.rdEn;
  end

  // Asynchronous output gating.
  assign rdValid = rdValidQ & ~oeN;
  assign rdData  = rdValid ? rdQ : '0;
endmodule

// File: rtl/sram_bw_top.sv
`timescale 1ns/1ps
module sram_bw_top
  import sram_bw_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bselN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              oeN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  strobe_t strb;

  sram_bw_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .selN  (selN),
    .gwN   (gwN),
    .bweN  (bweN),
    .bselN (bselN),
    .strb  (strb)
  );

  sram_bw_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrData  (wrData),
    .strb    (strb),
    .oeN     (oeN),
    .rdData  (rdData),
    .rdValid (rdValid)
  );
endmodule

// File: rtl/sram_bw_checker.sv
`timescale 1ns/1ps
module sram_bw_checker
  import sram_bw_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              selN,
  input logic              gwN,
  input logic              bweN,
  input logic              oeN,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid
);
  // R6: a selected read with byte-write disabled is valid two edges later unless output is disabled
  a_r6_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && gwN && bweN) |=> ##1 (oeN || rdValid));

  // R7: a deselected cycle produces no valid output
  a_r7_deselect_idle: assert property (@(posedge clk) disable iff (!rstN)
    selN |=> ##1 !rdValid);

  // R10: a global write cycle produces no valid output
  a_r10_write_no_out: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && !gwN) |=> ##1 !rdValid);

  // R8: output enable high keeps the valid flag low
  a_r8_oe_masks: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !rdValid);

  // R11: data bus is zero whenever not valid
  a_r11_zero_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));
endmodule

bind sram_bw_top sram_bw_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .selN    (selN),
  .gwN     (gwN),
  .bweN    (bweN),
  .oeN     (oeN),
  .rdData  (rdData),
  .rdValid (rdValid)
);

// File: tb/sram_bw_top_test.sv
`timescale 1ns/1ps
module sram_bw_top_test;
  import sram_bw_pkg::*;
  localparam int ADDR_W = 10;
  localparam int NADDR  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              selN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              gwN = 1'b1;
  logic              bweN = 1'b1;
  logic [LANES-1:0]  bselN = '1;
  logic [DATA_W-1:0] wrData = '0;
  logic              oeN = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic              rdValid;

  sram_bw_top #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .selN(selN), .addr(addr), .gwN(gwN),
    .bweN(bweN), .bselN(bselN), .wrData(wrData), .oeN(oeN),
    .rdData(rdData), .rdValid(rdValid)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  int pc = 0;
  logic [DATA_W-1:0] refMem [0:NADDR-1];

  bit                qRd[$];
  logic [DATA_W-1:0] qDat[$];
  int                qDue[$];
  string             qTag[$];

  task automatic check(string tag, bit ok, logic [DATA_W:0] act, logic [DATA_W:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual {valid,data}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // Driver: applies one access and pushes what the output must show two edges later.
  task automatic access(bit sN, bit gN, bit bN, logic [3:0] bs, int a,
                        logic [DATA_W-1:0] d, bit oe, string tag);
    bit isRd;
    bit anyW;
    @(negedge clk);
    selN = sN; gwN = gN; bweN = bN; bselN = bs; addr = a[ADDR_W-1:0];
    wrData = d; oeN = oe;
    anyW = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!sN && (!gN || (!bN && !bs[i]))) begin
        refMem[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
        anyW = 1'b1;
      end
    end
    isRd = !sN && !anyW;
    qRd.push_back(isRd);
    qDat.push_back(isRd ? refMem[a] : '0);
    qDue.push_back(pc + 2);
    qTag.push_back(tag);
  endtask

  // Monitor: compares the output after each rising edge against due items.
  initial begin
    forever begin
      @(posedge clk);
      pc++;
      #3;
      while (qDue.size() > 0 && qDue[0] == pc) begin
        bit rd;
        bit expV;
        logic [DATA_W-1:0] ed;
        string tg;
        rd = qRd.pop_front(); ed = qDat.pop_front();
        void'(qDue.pop_front()); tg = qTag.pop_front();
        expV = rd && !oeN;
        if (!expV) ed = '0;
        check(tg, (rdValid === expV) && (rdData === ed), {rdValid, rdData}, {expV, ed});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", (rdValid === 1'b0) && (rdData === '0), {rdValid, rdData}, '0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1", (rdValid === 1'b0) && (rdData === '0), {rdValid, rdData}, '0);

    // R3: global write, byte controls in varied states
    for (int a = 0; a < NADDR; a++)
      access(0, 0, a[0], a[3:0], a, 32'hA5000000 | (a * 32'h00010203), 0, "R3");
    // R9: immediate read of last write, then read all back-to-back (R6)
    access(0, 1, 1, 4'hF, NADDR - 1, '0, 0, "R9");
    for (int a = 0; a < NADDR; a++) access(0, 1, 1, 4'hF, a, '0, 0, "R6");

    // R2: single-lane writes, each followed by a read
    for (int i = 0; i < LANES; i++) begin
      logic [3:0] bs;
      bs = 4'hF; bs[i] = 1'b0;
      access(0, 1, 0, bs, 1, 32'h11223344 + i, 0, "R2");
      access(0, 1, 1, 4'hF, 1, '0, 0, "R2");
    end
    access(0, 1, 0, 4'b1010, 2, 32'hDEADBEEF, 0, "R2");
    access(0, 1, 1, 4'hF, 2, '0, 0, "R2");

    // R4: selects ignored while byte-write enable is high
    access(0, 1, 1, 4'b0000, 3, 32'hFFFFFFFF, 0, "R4");
    access(0, 1, 1, 4'hF, 3, '0, 0, "R4");
    // R5: byte-write enable low but no lane selected
    access(0, 1, 0, 4'b1111, 4, 32'h0BADF00D, 0, "R5");
    access(0, 1, 1, 4'hF, 4, '0, 0, "R5");

    // R7: deselected global write does nothing
    access(1, 0, 0, 4'h0, 5, 32'h12345678, 0, "R7");
    access(0, 1, 1, 4'hF, 5, '0, 0, "R7");
    // R10: write cycle yields no valid output
    access(0, 0, 1, 4'hF, 6, 32'h66666666, 0, "R10");
    access(0, 1, 1, 4'hF, 6, '0, 0, "R10");

    // R8: output enable high during a read
    access(0, 1, 1, 4'hF, 7, '0, 1, "R8");
    access(0, 1, 1, 4'hF, 7, '0, 1, "R8");
    // R8: asynchronous toggle within one cycle
    access(0, 1, 1, 4'hF, 8, '0, 0, "R8");
    access(1, 1, 1, 4'hF, 0, '0, 0, "R7");
    @(posedge clk);
    #4 oeN = 1'b1;
    #0.2 check("R8", (rdValid === 1'b0) && (rdData === '0), {rdValid, rdData}, '0);
    oeN = 1'b0;
    #0.2 check("R8", (rdValid === 1'b1) && (rdData === refMem[8]),
                {rdValid, rdData}, {1'b1, refMem[8]});

    // R9: mixed traffic with back-to-back read-after-write
    seed = 32'h1F2E3D4C;
    for (int n = 0; n < 300; n++) begin
      int a;
      int op;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
      a = (seed >>> 4) & (NADDR - 1);
      op = seed & 3;
      case (op)
        0: access(0, 1, 1, 4'hF, a, '0, ((seed >>> 9) & 7) == 0, "R9");
        1: access(0, 0, 1, 4'hF, a, seed, 0, "R9");
        2: access(0, 1, 0, 4'((seed >>> 12) & 15), a, ~seed, 0, "R9");
        default: access(1, (seed >>> 20) & 1, 0, 4'h0, a, seed, 0, "R9");
      endcase
    end
    for (int a = 0; a < NADDR; a++) access(0, 1, 1, 4'hF, a, '0, 0, "R9");
    access(1, 1, 1, 4'hF, 0, '0, 0, "R7");
    repeat (4) @(negedge clk);
    if (qDue.size() != 0) check("R6", 1'b0, qDue.size(), 0);
    finishRun();
  end
endmodule